// File: doc/BRIEF.md
# Per-PHY Transmit Cell Rate Pacer

This block sets the pace at which ATM cells leave toward up to four PHY addresses. Each PHY has a down-counting rate timer with its own reload register, written by software. All timers advance on a tick taken from one of four baud-rate-generator enable inputs, picked by a select input. A timer that runs out while its PHY's transmit FIFO holds a cell asks for one cell to be sent. A timer that runs out while the FIFO is empty sends nothing and raises an underrun event instead.

In slave operation only the first timer runs, and it paces the single configured slave address. Events are kept in a 16-bit sticky register whose bits are cleared by writing ones. A companion mask register gates the events onto a level interrupt output. The cell datapath and the FIFO storage sit outside the block; it sees only one "holds a cell" flag per PHY.

Top module: `tx_cell_pacer`

## Requirements
- R1: After reset the event register, mask register and all timer counts are zero and no send request is active, so the first selected tick with the mode enabled expires every running timer.
- R2: A timer whose reload value is N expires on one selected tick out of every N+1 and reloads on the tick it expires; a reload value of 0 expires on every selected tick.
- R3: Only `brg_tick[tick_sel]` advances the timers; pulses on the other three tick inputs have no effect on sends or events.
- R4: Each expiry with the PHY's `fifo_has_cell` bit at 1 yields exactly one single-cycle `send_req`, with `send_addr` equal to the PHY index, starting the cycle after the tick edge.
- R5: When several timers expire on the same tick, their send requests come out one per cycle in ascending PHY index order.
- R6: An expiry with the PHY's `fifo_has_cell` bit at 0 produces no send and sets the underrun event, bit index 10 of `evt_q` (position 5 counting from the MSB as 0).
- R7: With `pace_en` low all timers hold their counts, and no send and no underrun can occur; counting resumes from the held values when it returns high.
- R8: With `slave_mode` high only timer 0 runs, using `fifo_has_cell[0]`, and every send request carries `send_addr` equal to `slave_addr`; timers 1 to 3 hold.
- R9: `evt_q` is 16 bits; indices 15 to 11 always read zero, index 10 is the underrun flag, and indices 9 to 0 are set by the matching bits of `ext_evt_set`.
- R10: Writing `evt_wr_data` with `evt_wr_en` clears the event bits where the data is 1 and leaves the rest unchanged; a set arriving in the same cycle wins over the clear.
- R11: `irq` is high exactly while some bit is 1 in both `evt_q` and `mask_q`; `mask_we` loads `mask_q` from `mask_wdata`.
- R12: Writing a timer's reload value (via `init_we`, `init_idx`, `init_wdata`) does not change its running count; the new value is used from that timer's next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pace_en | input | 1 | Internal rate pacing enable |
| slave_mode | input | 1 | Single-address slave operation |
| slave_addr | input | 5 | PHY address reported in slave operation |
| brg_tick | input | 4 | Baud-rate-generator tick enables |
| tick_sel | input | 2 | Selects the tick input that drives the timers |
| fifo_has_cell | input | 4 | Per-PHY transmit FIFO holds a cell |
| init_we | input | 1 | Reload value write strobe |
| init_idx | input | 2 | Timer addressed by the reload write |
| init_wdata | input | 16 | Reload value |
| evt_wr_en | input | 1 | Event clear strobe |
| evt_wr_data | input | 16 | Ones clear the matching event bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask value |
| ext_evt_set | input | 10 | Set pulses for event indices 9 to 0 |
| send_req | output | 1 | One-cycle request to send a cell |
| send_addr | output | 5 | PHY address of the request |
| evt_q | output | 16 | Event register |
| mask_q | output | 16 | Mask register |
| irq | output | 1 | Masked event interrupt |

## Verification
A counter that reloads wrongly or advances on the wrong tick shows at the ports within one timer period as a send with an unexpected address, a missing send, or a stray underrun bit. The bench keeps its own model of every count and reload value and predicts each send address in order. A pending send that is lost or duplicated shows within the few cycles the arbiter needs to drain. A wrong event register state shows on `evt_q` and `irq` the cycle after the stimulus that caused it.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int EVT_W       = 16;
  localparam int UNDERRUN_IX = 10;
  localparam int EXT_EVT_W   = UNDERRUN_IX;
  localparam int RSVD_LO     = UNDERRUN_IX + 1;
  localparam logic [EVT_W-1:0] EVT_VALID = EVT_W'((1 << RSVD_LO) - 1);
  typedef logic [EVT_W-1:0] evt_vec_t;
endpackage

// File: rtl/pacer_tick_mux.sv
module pacer_tick_mux #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) tick_o = src_i[i];
    end
  end
endmodule

// File: rtl/pacer_rate_timer.sv
module pacer_rate_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             ld_we_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step     = tick_i & run_i;
  assign expire_o = step & (cnt_q == '0);

  always_comb begin
    reload_d = reload_q;
    if (ld_we_i) reload_d = ld_val_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (step) begin
      if (cnt_q == '0) cnt_d = reload_q;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (ld_we_i) reload_q <= reload_d;
      if (step)    cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/pacer_send_arb.sv
module pacer_send_arb #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] grant;
  logic         upd;

  assign grant = pend_q & (~pend_q + 1'b1);
  assign req_o = |pend_q;
  assign upd   = req_o | (|set_i);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    pend_d = (pend_q & ~grant) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end
endmodule

// File: rtl/pacer_event_regs.sv
module pacer_event_regs
  import pacer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t set_i,
  input  logic     clr_we_i,
  input  evt_vec_t clr_data_i,
  input  logic     mask_we_i,
  input  evt_vec_t mask_data_i,
  output evt_vec_t evt_o,
  output evt_vec_t mask_o,
  output logic     irq_o
);
  evt_vec_t evt_q, evt_d;
  evt_vec_t mask_q, mask_d;
  evt_vec_t clr_vec;
  logic     evt_upd;

  assign clr_vec = clr_we_i ? clr_data_i : '0;
  assign evt_upd = clr_we_i | (|set_i);

  always_comb begin
    evt_d = ((evt_q & ~clr_vec) | set_i) & EVT_VALID;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_we_i) mask_d = mask_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      if (evt_upd)   evt_q  <= evt_d;
      if (mask_we_i) mask_q <= mask_d;
    end
  end

  assign evt_o  = evt_q;
  assign mask_o = mask_q;
  assign irq_o  = |(evt_q & mask_q);
endmodule

// File: rtl/tx_cell_pacer.sv
module tx_cell_pacer
  import pacer_pkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int NUM_BRG = 4,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 5,
  localparam int SEL_W  = (NUM_BRG > 1) ? $clog2(NUM_BRG) : 1,
  localparam int PHY_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pace_en,
  input  logic                  slave_mode,
  input  logic [ADDR_W-1:0]     slave_addr,
  input  logic [NUM_BRG-1:0]    brg_tick,
  input  logic [SEL_W-1:0]      tick_sel,
  input  logic [NUM_PHY-1:0]    fifo_has_cell,
  input  logic                  init_we,
  input  logic [PHY_W-1:0]      init_idx,
  input  logic [CNT_W-1:0]      init_wdata,
  input  logic                  evt_wr_en,
  input  logic [EVT_W-1:0]      evt_wr_data,
  input  logic                  mask_we,
  input  logic [EVT_W-1:0]      mask_wdata,
  input  logic [EXT_EVT_W-1:0]  ext_evt_set,
  output logic                  send_req,
  output logic [ADDR_W-1:0]     send_addr,
  output logic [EVT_W-1:0]      evt_q,
  output logic [EVT_W-1:0]      mask_q,
  output logic                  irq
);
  logic               tick_hit;
  logic [NUM_PHY-1:0] run_vec;
  logic [NUM_PHY-1:0] expire_vec;
  logic [NUM_PHY-1:0] send_set;
  logic               underrun_hit;
  logic [PHY_W-1:0]   send_idx;
  evt_vec_t           evt_set;

  pacer_tick_mux #(.NUM_SRC(NUM_BRG)) tick_mux_i (
    .src_i  (brg_tick),
    .sel_i  (tick_sel),
    .tick_o (tick_hit)
  );

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_timer
    if (g == 0) begin : g_lead
      assign run_vec[g] = pace_en;
    end else begin : g_follow
      assign run_vec[g] = pace_en & ~slave_mode;
    end

    pacer_rate_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_hit),
      .run_i    (run_vec[g]),
      .ld_we_i  (init_we && (init_idx == PHY_W'(g))),
      .ld_val_i (init_wdata),
      .expire_o (expire_vec[g])
    );
  end

  assign send_set     = expire_vec & fifo_has_cell;
  assign underrun_hit = |(expire_vec & ~fifo_has_cell);

  pacer_send_arb #(.N(NUM_PHY)) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (send_set),
    .req_o (send_req),
    .idx_o (send_idx)
  );

  assign send_addr = slave_mode ? slave_addr : ADDR_W'(send_idx);

  always_comb begin
    evt_set = '0;
    evt_set[EXT_EVT_W-1:0] = ext_evt_set;
    evt_set[UNDERRUN_IX]   = underrun_hit;
  end

  pacer_event_regs event_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (evt_set),
    .clr_we_i    (evt_wr_en),
    .clr_data_i  (evt_wr_data),
    .mask_we_i   (mask_we),
    .mask_data_i (mask_wdata),
    .evt_o       (evt_q),
    .mask_o      (mask_q),
    .irq_o       (irq)
  );
endmodule

// File: rtl/tx_cell_pacer_chk.sv
module tx_cell_pacer_chk
  import pacer_pkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int NUM_BRG = 4,
  localparam int SEL_W  = (NUM_BRG > 1) ? $clog2(NUM_BRG) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pace_en,
  input logic               slave_mode,
  input logic [NUM_BRG-1:0] brg_tick,
  input logic [SEL_W-1:0]   tick_sel,
  input logic               evt_wr_en,
  input logic [EVT_W-1:0]   evt_wr_data,
  input logic [EVT_W-1:0]   evt_q,
  input logic [EVT_W-1:0]   mask_q,
  input logic               irq,
  input logic [NUM_PHY-1:0] expire_vec,
  input logic               underrun_hit
);
  // R9: reserved indices never set
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[EVT_W-1:RSVD_LO] == '0);

  // R7: timers frozen while pacing is off
  a_r7_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pace_en |-> expire_vec == '0);

  // R8: only timer 0 may expire in slave operation
  a_r8_slave_single_timer: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> expire_vec[NUM_PHY-1:1] == '0);

  // R3: an expiry needs the selected tick
  a_r3_selected_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire_vec) |-> brg_tick[tick_sel]);

  // R10: a clear without a competing set empties the underrun flag
  a_r10_underrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr_en && evt_wr_data[UNDERRUN_IX] && !underrun_hit) |=> !evt_q[UNDERRUN_IX]);

  // R6: the underrun flag only rises after an empty-FIFO expiry
  a_r6_underrun_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[UNDERRUN_IX]) |-> $past(underrun_hit));

  // R11: no interrupt with an all-zero mask
  a_r11_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind tx_cell_pacer tx_cell_pacer_chk #(.NUM_PHY(NUM_PHY), .NUM_BRG(NUM_BRG)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pace_en      (pace_en),
  .slave_mode   (slave_mode),
  .brg_tick     (brg_tick),
  .tick_sel     (tick_sel),
  .evt_wr_en    (evt_wr_en),
  .evt_wr_data  (evt_wr_data),
  .evt_q        (evt_q),
  .mask_q       (mask_q),
  .irq          (irq),
  .expire_vec   (expire_vec),
  .underrun_hit (underrun_hit)
);

// File: tb/tx_cell_pacer_tb_top.sv
module tx_cell_pacer_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk;
  logic        rst_n;
  logic        pace_en;
  logic        slave_mode;
  logic [4:0]  slave_addr;
  logic [3:0]  brg_tick;
  logic [1:0]  tick_sel;
  logic [3:0]  fifo_has_cell;
  logic        init_we;
  logic [1:0]  init_idx;
  logic [15:0] init_wdata;
  logic        evt_wr_en;
  logic [15:0] evt_wr_data;
  logic        mask_we;
  logic [15:0] mask_wdata;
  logic [9:0]  ext_evt_set;
  logic        send_req;
  logic [4:0]  send_addr;
  logic [15:0] evt_q;
  logic [15:0] mask_q;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  int exp_q[$];
  int mcnt[4];
  int minit[4];
  logic [15:0] exp_evt;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  tx_cell_pacer dut_i (
    .clk(clk), .rst_n(rst_n), .pace_en(pace_en), .slave_mode(slave_mode),
    .slave_addr(slave_addr), .brg_tick(brg_tick), .tick_sel(tick_sel),
    .fifo_has_cell(fifo_has_cell), .init_we(init_we), .init_idx(init_idx),
    .init_wdata(init_wdata), .evt_wr_en(evt_wr_en), .evt_wr_data(evt_wr_data),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ext_evt_set(ext_evt_set),
    .send_req(send_req), .send_addr(send_addr), .evt_q(evt_q),
    .mask_q(mask_q), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected send addresses in order (R4, R5, R8)
  always @(negedge clk) begin
    if (rst_n && send_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected send", int'(send_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(send_addr) == e, "R4/R5/R8 send address", int'(send_addr), e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one tick pulse plus model update (R2, R3, R6, R7, R8)
  task automatic do_tick(input int src);
    @(negedge clk);
    brg_tick = 4'b0001 << src;
    if (pace_en && src == int'(tick_sel)) begin
      for (int i = 0; i < 4; i++) begin
        if (i == 0 || !slave_mode) begin
          if (mcnt[i] == 0) begin
            if (fifo_has_cell[i]) exp_q.push_back(slave_mode ? int'(slave_addr) : i);
            else exp_evt[10] = 1'b1;
            mcnt[i] = minit[i];
          end else begin
            mcnt[i] = mcnt[i] - 1;
          end
        end
      end
    end
    @(negedge clk);
    brg_tick = '0;
    idle(5);
  endtask

  task automatic write_init(input int idx, input int val);
    @(negedge clk);
    init_we = 1'b1; init_idx = 2'(idx); init_wdata = 16'(val);
    minit[idx] = val;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic write_evt(input logic [15:0] d);
    @(negedge clk);
    evt_wr_en = 1'b1; evt_wr_data = d;
    exp_evt = exp_evt & ~d;
    @(negedge clk);
    evt_wr_en = 1'b0;
  endtask

  task automatic write_mask(input logic [15:0] d);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = d;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic check_evt(input string req);
    @(negedge clk);
    check(evt_q == exp_evt, req, int'(evt_q), int'(exp_evt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pace_en = 1'b0; slave_mode = 1'b0; slave_addr = '0;
    brg_tick = '0; tick_sel = '0; fifo_has_cell = '0; init_we = 1'b0;
    init_idx = '0; init_wdata = '0; evt_wr_en = 1'b0; evt_wr_data = '0;
    mask_we = 1'b0; mask_wdata = '0; ext_evt_set = '0; exp_evt = '0;
    for (int i = 0; i < 4; i++) begin mcnt[i] = 0; minit[i] = 0; end
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    check(evt_q == 16'h0, "R1 evt reset", int'(evt_q), 0);
    check(mask_q == 16'h0, "R1 mask reset", int'(mask_q), 0);
    check(!irq && !send_req, "R1 outputs idle", int'({irq, send_req}), 0);

    // R2/R5/R12: reload values, first tick expires all four in order
    fifo_has_cell = 4'hF; pace_en = 1'b1;
    write_init(0, 0); write_init(1, 1); write_init(2, 2); write_init(3, 3);
    for (int k = 0; k < 8; k++) do_tick(0);
    check(exp_q.size() == 0, "R2 periodic sends drained", exp_q.size(), 0);

    // R3: non-selected sources ignored, then switch source
    do_tick(2); do_tick(1); do_tick(3);
    check(exp_q.size() == 0, "R3 other ticks ignored", exp_q.size(), 0);
    tick_sel = 2'd2;
    do_tick(0); do_tick(2); do_tick(2);
    check(exp_q.size() == 0, "R3 selected source", exp_q.size(), 0);

    // R12: new reload value only after next reload
    write_init(3, 0); write_init(0, 2);
    for (int k = 0; k < 6; k++) do_tick(2);
    check(exp_q.size() == 0, "R12 deferred reload", exp_q.size(), 0);

    // R6: empty FIFO gives underrun, no send
    fifo_has_cell = 4'b1101;
    for (int k = 0; k < 3; k++) do_tick(2);
    check_evt("R6 underrun flag");
    check(evt_q[10] == 1'b1, "R6 underrun bit 10", int'(evt_q[10]), 1);

    // R11: interrupt via mask
    write_mask(16'h0400);
    @(negedge clk);
    check(irq == 1'b1, "R11 irq masked in", int'(irq), 1);
    write_mask(16'h0001);
    @(negedge clk);
    check(irq == 1'b0, "R11 irq masked out", int'(irq), 0);

    // R10: zero write keeps, one write clears
    fifo_has_cell = 4'hF;
    write_evt(16'h0000);
    check_evt("R10 zero write keeps");
    write_evt(16'h0400);
    check_evt("R10 one write clears");

    // R10: set wins over clear in the same cycle
    @(negedge clk);
    ext_evt_set = 10'h001; evt_wr_en = 1'b1; evt_wr_data = 16'h0001;
    exp_evt[0] = 1'b1;
    @(negedge clk);
    ext_evt_set = '0; evt_wr_en = 1'b0;
    check_evt("R10 set wins");
    @(negedge clk);
    check(irq == 1'b1, "R11 irq from ext event", int'(irq), 1);

    // R9: external sets and reserved bits
    @(negedge clk);
    ext_evt_set = 10'h3FF;
    exp_evt[9:0] = 10'h3FF;
    @(negedge clk);
    ext_evt_set = '0;
    check_evt("R9 ext event bits");
    write_evt(16'hFFFF);
    check_evt("R9 cleared all");
    check(evt_q[15:11] == 5'h0, "R9 reserved zero", int'(evt_q[15:11]), 0);

    // R7: mode off holds timers, no send, no underrun
    pace_en = 1'b0; fifo_has_cell = 4'h0;
    for (int k = 0; k < 4; k++) do_tick(2);
    check_evt("R7 no underrun when off");
    check(exp_q.size() == 0, "R7 no sends when off", exp_q.size(), 0);
    pace_en = 1'b1; fifo_has_cell = 4'hF;
    for (int k = 0; k < 4; k++) do_tick(2);
    check(exp_q.size() == 0, "R7 resume from held counts", exp_q.size(), 0);

    // R8: slave operation, only timer 0, slave address
    slave_mode = 1'b1; slave_addr = 5'd21; fifo_has_cell = 4'b1110;
    for (int k = 0; k < 3; k++) do_tick(2);
    check_evt("R8 slave underrun via fifo bit 0");
    write_evt(16'h0400);
    fifo_has_cell = 4'b0001;
    for (int k = 0; k < 6; k++) do_tick(2);
    check(exp_q.size() == 0, "R8 slave sends", exp_q.size(), 0);
    check_evt("R8 slave events");

    idle(10);
    check(exp_q.size() == 0, "R4 all expected sends seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule